// File: doc/BRIEF.md
# Boot-Block Flash Command Interface

This block is the command front end of a byte-wide boot-block flash held in on-chip RAM. A host on a simple synchronous bus reaches it through an address, a write strobe with a data byte, and a read strobe with a registered read-data return. Command bytes written to any address choose what later reads return: array contents, the identifier bytes, or the status byte. Two-write sequences erase a whole block or program one byte. One small boot block can never be changed by either sequence.

The array is split into four blocks. The boot block takes one sixteenth of the array. Each of the two data blocks takes one thirty-second. The main block takes the rest. With `ADDR_W` = 17 (128 KiB), the top-boot map has main at 0x00000–0x1BFFF, data blocks at 0x1C000 and 0x1D000 (4 KiB each) and boot at 0x1E000–0x1FFFF. The bottom-boot map has boot at 0x00000–0x01FFF, data blocks at 0x02000 and 0x03000, and main from 0x04000 to the end. A second parameter flips the top address bit before anything else sees the address. This suits boards that wire that line inverted.

An erase clears its block one byte per clock. While it runs, bus writes are dropped and the status reads 0x00.

Top module: `bbflash_ctrl`

## Requirements
- R1: After reset the block returns array data on reads, and the status byte is 0x00.
- R2: Writing 0xFF selects array reads and writing 0x70 selects status reads. A selected read mode lasts until the next command. Any command byte that is not recognised is kept as the mode, and reads then return array data.
- R3: After 0x90 is written, a read at an even address returns 0x89. A read at an odd address returns 0x94 with the top-boot map or 0x95 with the bottom-boot map.
- R4: Writing 0x50 sets the status byte to 0x00.
- R5: Writing 0x20 and then 0xD0 fills the whole block that holds the second write's address with 0xFF, one byte per clock. The status reads 0x00 while this runs and 0x80 once the last byte is written.
- R6: After 0x20, a second write whose data is not 0xD0 changes no array byte and leaves the status unchanged. It still switches reads to status.
- R7: An erase confirm inside the boot block erases nothing, sets the status to 0x80 and switches reads to status.
- R8: Bus writes made while an erase is running have no effect on the mode or the status.
- R9: Writing 0x40 or 0x10 records the write address. The next write stores its data only when its address equals the recorded one and lies outside the boot block. Either way, the status becomes 0x80 and reads switch to status.
- R10: The `BOTTOM_BOOT` parameter places the blocks as given above, scaled to 2^`ADDR_W` bytes.
- R11: With `INVERT_MSB` set, the top address bit is flipped before block decode, identifier decode and array access, for both reads and writes.
- R12: Read data appears the clock after the read strobe and holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command byte |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |

## Verification
Four instances cover both block maps against both settings of the address flip, each on a 256-byte array. The identifier sweep reads every address, which separates the even/odd decode from the device code. Every non-boot block is erased through an address inside it, then the whole array is read back, which shows whether the block edges and the address flip are decoded right. A program sweep writes an address-derived byte at every address, mixing both setup codes, followed by a mismatched-address program, a wrong confirm and a boot-block erase. A final full read-back then tells a protected byte from a changed one.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {BLK_MAIN, BLK_DATA1, BLK_DATA2, BLK_BOOT} blk_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STAT    = 8'h70;
  localparam logic [7:0] CMD_CLR     = 8'h50;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;

  localparam logic [7:0] MFR_CODE    = 8'h89;
  localparam logic [7:0] DEV_TOP     = 8'h94;
  localparam logic [7:0] DEV_BOT     = 8'h95;
  localparam logic [7:0] ST_READY    = 8'h80;
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/flash_blk_map.sv
module flash_blk_map
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output blk_e              blk,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last
);
  localparam int SIZE     = 1 << ADDR_W;
  localparam int BOOT_LEN = SIZE / 16;
  localparam int DATA_LEN = SIZE / 32;

  generate
    if (BOTTOM_BOOT) begin : g_bottom
      localparam logic [ADDR_W-1:0] D1_LO = ADDR_W'(BOOT_LEN);
      localparam logic [ADDR_W-1:0] D2_LO = ADDR_W'(BOOT_LEN + DATA_LEN);
      localparam logic [ADDR_W-1:0] MN_LO = ADDR_W'(BOOT_LEN + 2 * DATA_LEN);
      always_comb begin
        if (addr < D1_LO) begin
          blk = BLK_BOOT;  base = '0;    last = D1_LO - 1'b1;
        end else if (addr < D2_LO) begin
          blk = BLK_DATA1; base = D1_LO; last = D2_LO - 1'b1;
        end else if (addr < MN_LO) begin
          blk = BLK_DATA2; base = D2_LO; last = MN_LO - 1'b1;
        end else begin
          blk = BLK_MAIN;  base = MN_LO; last = '1;
        end
      end
    end else begin : g_top
      localparam logic [ADDR_W-1:0] BT_LO = ADDR_W'(SIZE - BOOT_LEN);
      localparam logic [ADDR_W-1:0] D2_LO = ADDR_W'(SIZE - BOOT_LEN - DATA_LEN);
      localparam logic [ADDR_W-1:0] D1_LO = ADDR_W'(SIZE - BOOT_LEN - 2 * DATA_LEN);
      always_comb begin
        if (addr < D1_LO) begin
          blk = BLK_MAIN;  base = '0;    last = D1_LO - 1'b1;
        end else if (addr < D2_LO) begin
          blk = BLK_DATA1; base = D1_LO; last = D2_LO - 1'b1;
        end else if (addr < BT_LO) begin
          blk = BLK_DATA2; base = D2_LO; last = BT_LO - 1'b1;
        end else begin
          blk = BLK_BOOT;  base = BT_LO; last = '1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/flash_ram.sv
module flash_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  blk_e              blk,
  input  logic [ADDR_W-1:0] blk_base,
  input  logic [ADDR_W-1:0] blk_last,
  output logic [7:0]        mode,
  output logic [7:0]        status,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  logic [7:0]        mode_q, mode_n;
  logic [7:0]        stat_q, stat_n;
  logic              busy_q, busy_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [ADDR_W-1:0] end_q, end_n;
  logic [ADDR_W-1:0] pgm_q, pgm_n;

  always_comb begin
    mode_n    = mode_q;
    stat_n    = stat_q;
    busy_n    = busy_q;
    ptr_n     = ptr_q;
    end_n     = end_q;
    pgm_n     = pgm_q;
    mem_we    = 1'b0;
    mem_waddr = addr;
    mem_wdata = wdata;
    if (busy_q) begin
      // erase walk: one byte per clock, bus writes dropped
      mem_we    = 1'b1;
      mem_waddr = ptr_q;
      mem_wdata = 8'hFF;
      if (ptr_q == end_q) begin
        busy_n = 1'b0;
        stat_n = ST_READY;
      end else begin
        ptr_n = ptr_q + 1'b1;
      end
    end else if (wr_en) begin
      case (mode_q)
        CMD_ERASE: begin
          mode_n = CMD_STAT;
          if (wdata == CMD_CONFIRM) begin
            if (blk == BLK_BOOT) begin
              stat_n = ST_READY;
            end else begin
              busy_n = 1'b1;
              ptr_n  = blk_base;
              end_n  = blk_last;
              stat_n = 8'h00;
            end
          end
        end
        CMD_PROG_A, CMD_PROG_B: begin
          mode_n = CMD_STAT;
          stat_n = ST_READY;
          mem_we = (addr == pgm_q) && (blk != BLK_BOOT);
        end
        default: begin
          mode_n = wdata;
          if (wdata == CMD_CLR) stat_n = 8'h00;
          if (wdata == CMD_PROG_A || wdata == CMD_PROG_B) pgm_n = addr;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CMD_ARRAY;
      stat_q <= 8'h00;
      busy_q <= 1'b0;
      ptr_q  <= '0;
      end_q  <= '0;
      pgm_q  <= '0;
    end else begin
      mode_q <= mode_n;
      stat_q <= stat_n;
      busy_q <= busy_n;
      ptr_q  <= ptr_n;
      end_q  <= end_n;
      pgm_q  <= pgm_n;
    end
  end

  assign mode   = mode_q;
  assign status = stat_q;
  assign busy   = busy_q;
endmodule

// File: rtl/bbflash_ctrl.sv
module bbflash_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter bit BOTTOM_BOOT = 1'b0,
  parameter bit INVERT_MSB  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] FLIP     = {INVERT_MSB, {(ADDR_W-1){1'b0}}};
  localparam logic [7:0]        DEV_CODE = BOTTOM_BOOT ? DEV_BOT : DEV_TOP;

  logic              rst_n_s;
  logic [ADDR_W-1:0] addr_eff;
  blk_e              blk;
  logic [ADDR_W-1:0] blk_base, blk_last;
  logic [7:0]        mode, status;
  logic              busy;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [7:0]        ram_q;
  logic              rarr_q, rarr_n;
  logic [7:0]        rval_q, rval_n;

  assign addr_eff = addr ^ FLIP;

  flash_rst_sync rst_i (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  flash_blk_map #(.ADDR_W(ADDR_W), .BOTTOM_BOOT(BOTTOM_BOOT)) map_i (
    .addr(addr_eff), .blk(blk), .base(blk_base), .last(blk_last)
  );

  flash_wsm #(.ADDR_W(ADDR_W)) wsm_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr_eff), .wdata(wdata),
    .blk(blk), .blk_base(blk_base), .blk_last(blk_last),
    .mode(mode), .status(status), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  flash_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) ram_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_en), .raddr(addr_eff), .rdata(ram_q)
  );

  // read return: array byte comes from the RAM register, others from rval_q
  always_comb begin
    rarr_n = rarr_q;
    rval_n = rval_q;
    if (rd_en) begin
      if (mode == CMD_IDENT) begin
        rarr_n = 1'b0;
        rval_n = addr_eff[0] ? DEV_CODE : MFR_CODE;
      end else if (mode == CMD_STAT) begin
        rarr_n = 1'b0;
        rval_n = status;
      end else begin
        rarr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rarr_q <= 1'b0;
      rval_q <= 8'h00;
    end else begin
      rarr_q <= rarr_n;
      rval_q <= rval_n;
    end
  end

  assign rdata = rarr_q ? ram_q : rval_q;
endmodule

// File: rtl/bbflash_ctrl_chk.sv
module bbflash_ctrl_chk #(
  parameter int ADDR_W      = 11,
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [7:0]        mode,
  input logic [7:0]        status,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [7:0]        mem_wdata
);
  localparam int SIZE     = 1 << ADDR_W;
  localparam int BOOT_LEN = SIZE / 16;

  logic in_boot;
  logic arm_mode;
  always_comb begin
    in_boot  = BOTTOM_BOOT ? (int'(mem_waddr) < BOOT_LEN) : (int'(mem_waddr) >= SIZE - BOOT_LEN);
    arm_mode = (mode == 8'h20) || (mode == 8'h40) || (mode == 8'h10);
  end

  a_r5_busy_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == 8'h00);
  a_r5_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> status == 8'h80);
  a_r5_erase_writes_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_we && mem_wdata == 8'hFF));
  a_r7_boot_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_boot);
  a_r8_writes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(mode));
  a_r6_erase_arm_to_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && mode == 8'h20) |=> mode == 8'h70);
  a_r9_program_ends_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && (mode == 8'h40 || mode == 8'h10)) |=> (status == 8'h80 && mode == 8'h70));
  a_r4_clear_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !arm_mode && wdata == 8'h50) |=> status == 8'h00);
  a_r12_status_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 8'h70) |=> rdata == $past(status));
endmodule

bind bbflash_ctrl bbflash_ctrl_chk #(.ADDR_W(ADDR_W), .BOTTOM_BOOT(BOTTOM_BOOT)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
  .mode(mode), .status(status), .busy(busy),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
);

// File: tb/bbflash_ctrl_tb_unit.sv
module bbflash_ctrl_tb_unit #(
  parameter bit BOTTOM = 1'b0,
  parameter bit INV    = 1'b0
) (
  input  logic clk,
  output bit   done,
  output int   n_chk,
  output int   n_err
);
  localparam int AW   = 8;
  localparam int SZ   = 1 << AW;
  localparam int FLIP = INV ? (SZ / 2) : 0;
  localparam logic [7:0] DEV = BOTTOM ? 8'h95 : 8'h94;

  logic          rst_n, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;
  logic [7:0]    mdl [SZ];
  bit            known [SZ];

  bbflash_ctrl #(.ADDR_W(AW), .BOTTOM_BOOT(BOTTOM), .INVERT_MSB(INV)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  // block id of a physical address: 0 main, 1 data1, 2 data2, 3 boot
  function automatic int blk_of(input int p);
    if (BOTTOM) return (p < 16) ? 3 : (p < 24) ? 1 : (p < 32) ? 2 : 0;
    else        return (p < 224) ? 0 : (p < 232) ? 1 : (p < 240) ? 2 : 3;
  endfunction

  // bus address (before the optional flip) of a byte inside block b
  function automatic int pick(input int b);
    for (int q = 0; q < SZ; q++)
      if (blk_of(q) == b) return (q + 1) ^ FLIP;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (bottom=%0d inv=%0d) actual=%02h expected=%02h", tag, BOTTOM, INV, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = a[AW-1:0]; wdata = d[7:0]; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = a[AW-1:0]; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] v;
    v = 8'h00;
    for (int i = 0; i < 400 && v != 8'h80; i++) rd(0, v);
    chk(v == 8'h80, tag, v, 8'h80);
  endtask

  task automatic model_erase(input int b);
    for (int q = 0; q < SZ; q++)
      if (blk_of(q) == b) begin mdl[q] = 8'hFF; known[q] = 1'b1; end
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v;
    for (int a = 0; a < SZ; a++) begin
      rd(a, v);
      if (known[a ^ FLIP]) chk(v == mdl[a ^ FLIP], tag, v, mdl[a ^ FLIP]);
      else begin mdl[a ^ FLIP] = v; known[a ^ FLIP] = 1'b1; end
    end
  endtask

  initial begin
    logic [7:0] v;
    int a;
    done = 1'b0; n_chk = 0; n_err = 0;
    for (int q = 0; q < SZ; q++) known[q] = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: status clear out of reset
    wr(0, 8'h70); rd(0, v); chk(v == 8'h00, "R1 reset status", v, 8'h00);

    // R3 / R11: identifier at every address
    wr(5, 8'h90);
    for (int i = 0; i < SZ; i++) begin
      rd(i, v);
      chk(v == ((i & 1) ? DEV : 8'h89), "R3 identifier", v, (i & 1) ? DEV : 8'h89);
    end

    // R12: read data held after strobe
    rd(3, v); repeat (3) @(negedge clk);
    chk(rdata == DEV && v == DEV, "R12 read hold", rdata, DEV);

    // R5 / R10 / R11: erase each non-boot block through a bus address inside it
    for (int b = 0; b < 3; b++) begin
      a = pick(b);
      wr(a, 8'h20); wr(a, 8'hD0);
      rd(0, v); chk(v == 8'h00, "R5 busy status", v, 8'h00);
      wait_ready("R5 erase ready");
      model_erase(b);
    end
    wr(0, 8'hFF);
    sweep("R10 R11 block erase contents");

    // R7: boot erase is refused but completes
    wr(0, 8'h50);
    a = pick(3); wr(a, 8'h20); wr(a, 8'hD0);
    rd(a, v); chk(v == 8'h80, "R7 boot erase status", v, 8'h80);

    // R4: clear status
    wr(0, 8'h50); wr(0, 8'h70); rd(0, v); chk(v == 8'h00, "R4 clear", v, 8'h00);

    // R8: writes during a running erase are dropped
    a = pick(0);
    wr(a, 8'h20); wr(a, 8'hD0); wr(a, 8'h50); wr(a, 8'h90); wr(a, 8'hFF);
    wait_ready("R8 status after ignored writes");
    rd(3, v); chk(v == 8'h80, "R8 mode kept", v, 8'h80);

    // R9: program every address, alternating setup codes
    for (int i = 0; i < SZ; i++) begin
      wr(i, (i & 1) ? 8'h10 : 8'h40);
      wr(i, (i * 29 + 7) & 8'hFF);
      if (blk_of(i ^ FLIP) != 3) mdl[i ^ FLIP] = 8'((i * 29 + 7) & 8'hFF);
      if ((i % 32) == 0) begin
        rd(i, v); chk(v == 8'h80, "R9 program status", v, 8'h80);
      end
    end
    // R9: address mismatch stores nothing
    a = pick(1);
    wr(a, 8'h40); wr(a ^ 2, 8'h5A);
    rd(a, v); chk(v == 8'h80, "R9 mismatch status", v, 8'h80);

    // R6: wrong confirm byte
    wr(0, 8'h50);
    wr(a, 8'h20); wr(a, 8'h33);
    rd(a, v); chk(v == 8'h00, "R6 wrong confirm status", v, 8'h00);

    // R2: unknown command returns array data; full read-back covers R6 R7 R9 R11
    wr(0, 8'h42);
    sweep("R2 R6 R7 R9 R11 array after programs");
    wr(0, 8'h70); rd(0, v); chk(v == 8'h00, "R2 status mode", v, 8'h00);
    wr(0, 8'hFF); rd(a, v); chk(v == mdl[a ^ FLIP], "R2 array mode", v, mdl[a ^ FLIP]);

    // R1: reset returns to array mode with status 0x00
    a = pick(0);
    wr(a, 8'h40); wr(a, mdl[a ^ FLIP]);
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    rd(a, v); chk(v == mdl[a ^ FLIP], "R1 array mode after reset", v, mdl[a ^ FLIP]);
    wr(0, 8'h70); rd(0, v); chk(v == 8'h00, "R1 status after reset", v, 8'h00);

    done = 1'b1;
  end
endmodule

// File: tb/bbflash_ctrl_tb_top.sv
module bbflash_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  bit done [4];
  int chk_a [4];
  int err_a [4];

  generate
    for (genvar g = 0; g < 4; g++) begin : g_cfg
      bbflash_ctrl_tb_unit #(.BOTTOM(g / 2 != 0), .INV(g % 2 != 0)) u_i (
        .clk(clk), .done(done[g]), .n_chk(chk_a[g]), .n_err(err_a[g])
      );
    end
  endgenerate

  initial begin
    int cyc, tot_chk, tot_err;
    bit all_done;
    cyc = 0; all_done = 1'b0;
    while (!all_done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
      all_done = done[0] && done[1] && done[2] && done[3];
    end
    #1;
    tot_chk = 0; tot_err = 0;
    for (int i = 0; i < 4; i++) begin
      tot_chk += chk_a[i];
      tot_err += err_a[i];
    end
    if (!all_done) begin
      tot_chk++; tot_err++;
      $display("FAIL watchdog R1-sequence not completed actual=%0d expected<%0d", cyc, 100000);
    end
    $display("CHECKS %0d ERRORS %0d", tot_chk, tot_err);
    $finish;
  end
endmodule